// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single-word requests from on-chip logic into accesses on an external bus whose address and data share one group of pins. A request is offered on a valid/ready port. Once the request is accepted, the block drives the address for one clock, marked by an address-latch strobe. It then drives a read strobe, or one write strobe per byte lane, for one clock plus the wait count of the memory area that the address falls in. A zero-wait access occupies the bus for two clocks. Each access ends with a one-cycle response pulse. For reads, that pulse carries the captured data.

Four area entries each hold a tag base, a tag mask and a 3-bit wait count. The tag is formed from the upper address bits. The bus runs 16 bits wide or 8 bits wide, and in 16-bit mode the two byte lanes can be exchanged to give little-endian order. In 8-bit mode the upper address byte is driven on a separate group of pins for the whole access. Whichever pin group the selected width leaves idle is flagged as free for general-purpose port use.

Back-pressure rules: `req_ready` is high only while no access is in progress, including the cycle of a response pulse. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its fields are captured at that edge. The response has no ready and cannot be stalled. The configuration inputs must stay stable while an access is in progress. `ADDR_W` must equal `DATA_W`.

Top module: `mxb_ctrl`

## Requirements
- R1: While idle, `req_ready` is 1. After a request is accepted, `bus_ale` is 1 for exactly the next cycle and `req_ready` is 0 during that cycle. In 16-bit mode `bus_ad_out` carries the whole address with `bus_ad_oe`=FFFF. In 8-bit mode `bus_ad_out[7:0]` carries address bits 7:0 with `bus_ad_oe`=00FF.
- R2: In the cycle after the address phase, the strobe phase begins and lasts 1+W cycles, where W is the area wait count. Strobes are never active during the address phase, and read and write strobes are never active together. A whole access therefore takes 2+W cycles.
- R3: The tag is address bits 15:12. Entry i (wait count at `cfg_area_wait[3i+2:3i]`, base and mask at bits [4i+3:4i]) matches when ((tag XOR base) AND mask) is 0. The lowest matching index sets W. When no entry matches, W is 7.
- R4: During a read strobe `bus_rd_n` is 0 and `bus_ad_oe` is 0. `bus_ad_in` is sampled at the clock edge where `bus_rd_n` returns to 1. In the following cycle `rsp_valid` is 1 for one cycle and `rsp_rdata` holds the sampled data.
- R5: During a 16-bit write strobe, `bus_ad_out` carries the write data and `bus_wr_n[k]` is 0 exactly for the external lanes k whose byte enable is set. With no byte enable set, no strobe goes low, but the access still takes 2+W cycles and ends with `rsp_valid`.
- R6: With `cfg_little`=1 in 16-bit mode, bytes 15:8 and 7:0 are exchanged between the internal side and the pins. This applies to write data, read data and byte enables.
- R7: In 8-bit mode, write data bits 7:0 appear on `bus_ad_out[7:0]`, only `bus_wr_n[0]` is driven low on writes whatever the byte enables, and `rsp_rdata` is {8'h00, `bus_ad_in[7:0]`}. `cfg_little` has no effect in this mode.
- R8: In 8-bit mode, `bus_ahi_oe` is 1 and `bus_ahi_out` equals address bits 15:8 throughout the address and strobe phases, `bus_ad_oe[15:8]` stays 0 and `port_free_adhi` is 1. In 16-bit mode, `bus_ahi_oe` stays 0 and `port_free_ahi` is 1.
- R9: After reset, `bus_ale`=0, `bus_rd_n`=1, `bus_wr_n`=11, `bus_ad_oe`=0, `bus_ahi_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R10: `req_ready` is 1 in the cycle in which `rsp_valid` pulses, so a new request offered then is accepted and its address phase directly follows the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bus16 | input | 1 | 1: 16-bit data bus, 0: 8-bit |
| cfg_little | input | 1 | 1: exchange byte lanes in 16-bit mode |
| cfg_area_base | input | 16 | Four 4-bit tag bases |
| cfg_area_mask | input | 16 | Four 4-bit tag masks |
| cfg_area_wait | input | 12 | Four 3-bit wait counts |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit k for bits 8k+7:8k |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| bus_ale | output | 1 | Address-latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 2 | Per-lane write strobes, active low |
| bus_ad_out | output | 16 | Shared address/data pins, driven value |
| bus_ad_oe | output | 16 | Per-pin output enable for shared pins |
| bus_ad_in | input | 16 | Shared address/data pins, sampled value |
| bus_ahi_out | output | 8 | Upper address byte in 8-bit mode |
| bus_ahi_oe | output | 1 | Enable for upper address pins |
| port_free_adhi | output | 1 | Shared pins 15:8 free for port use |
| port_free_ahi | output | 1 | Upper address pins free for port use |

## Verification
Two things fall in the same cycle: the response pulse that closes one access and the acceptance of the next request. Each access in the sweep is offered at the very edge on which the previous response is presented, so every one of several hundred accesses lands on this overlap. In that cycle the bench requires `rsp_valid`, `req_ready` and the correct read data all at once. In the next cycle it requires a clean address phase carrying the new address, with strobes released. These accesses cover every wait count, both widths and both byte orders.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } mxb_phase_e;
endpackage

// File: rtl/mxb_area_dec.sv
module mxb_area_dec #(
  parameter int AREAS  = 4,
  parameter int AREA_W = 4,
  parameter int WAIT_W = 3
) (
  input  logic [AREA_W-1:0]        tag_i,
  input  logic [AREAS*AREA_W-1:0]  base_i,
  input  logic [AREAS*AREA_W-1:0]  mask_i,
  input  logic [AREAS*WAIT_W-1:0]  wait_i,
  output logic [WAIT_W-1:0]        wait_o
);
  logic [AREAS-1:0] hit;

  for (genvar g = 0; g < AREAS; g++) begin : g_hit
    assign hit[g] = ((tag_i ^ base_i[g*AREA_W +: AREA_W])
                     & mask_i[g*AREA_W +: AREA_W]) == '0;
  end

  // lowest matching index wins; a miss gives the longest wait
  always_comb begin
    wait_o = '1;
    for (int i = AREAS - 1; i >= 0; i--) begin
      if (hit[i]) wait_o = wait_i[i*WAIT_W +: WAIT_W];
    end
  end
endmodule

// File: rtl/mxb_lane.sv
module mxb_lane #(
  parameter int LANES = 2
) (
  input  logic               swap_i,
  input  logic               narrow_i,
  input  logic [LANES*8-1:0] wdata_i,
  input  logic [LANES*8-1:0] ad_i,
  input  logic [LANES-1:0]   be_i,
  output logic [LANES*8-1:0] wdata_o,
  output logic [LANES*8-1:0] rdata_o,
  output logic [LANES-1:0]   lane_en_o
);
  localparam int DW = LANES * 8;

  logic [DW-1:0]    wd_wide;
  logic [DW-1:0]    rd_wide;
  logic [LANES-1:0] en_wide;

  for (genvar g = 0; g < LANES; g++) begin : g_map
    localparam int S = LANES - 1 - g;
    assign wd_wide[g*8 +: 8] = swap_i ? wdata_i[S*8 +: 8] : wdata_i[g*8 +: 8];
    assign rd_wide[g*8 +: 8] = swap_i ? ad_i[S*8 +: 8]    : ad_i[g*8 +: 8];
    assign en_wide[g]        = swap_i ? be_i[S]           : be_i[g];
  end

  assign wdata_o   = narrow_i ? {{(DW-8){1'b0}}, wdata_i[7:0]} : wd_wide;
  assign rdata_o   = narrow_i ? {{(DW-8){1'b0}}, ad_i[7:0]}    : rd_wide;
  assign lane_en_o = narrow_i ? {{(LANES-1){1'b0}}, 1'b1}      : en_wide;
endmodule

// File: rtl/mxb_seq.sv
module mxb_seq
  import mxb_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] wait_i,
  output mxb_phase_e        phase_o,
  output logic              last_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_o)
        PH_IDLE: if (start_i) begin
          phase_o <= PH_ADDR;
          cnt_q   <= wait_i;
        end
        PH_ADDR: phase_o <= PH_DATA;
        PH_DATA: begin
          if (cnt_q == '0) phase_o <= PH_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: phase_o <= PH_IDLE;
      endcase
    end
  end

  assign last_o = (phase_o == PH_DATA) && (cnt_q == '0);
endmodule

// File: rtl/mxb_ctrl.sv
module mxb_ctrl
  import mxb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int AREAS  = 4,
  parameter int AREA_W = 4,
  parameter int WAIT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_bus16,
  input  logic                     cfg_little,
  input  logic [AREAS*AREA_W-1:0]  cfg_area_base,
  input  logic [AREAS*AREA_W-1:0]  cfg_area_mask,
  input  logic [AREAS*WAIT_W-1:0]  cfg_area_wait,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W/8-1:0]      req_be,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     bus_ale,
  output logic                     bus_rd_n,
  output logic [DATA_W/8-1:0]      bus_wr_n,
  output logic [DATA_W-1:0]        bus_ad_out,
  output logic [DATA_W-1:0]        bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_in,
  output logic [ADDR_W-9:0]        bus_ahi_out,
  output logic                     bus_ahi_oe,
  output logic                     port_free_adhi,
  output logic                     port_free_ahi
);
  localparam int LANES = DATA_W / 8;
  localparam int HI_W  = ADDR_W - 8;

  mxb_phase_e        phase;
  logic              last;
  logic              start;
  logic              narrow;
  logic [WAIT_W-1:0] area_wait;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic              write_q;

  logic [DATA_W-1:0] wd_ext;
  logic [DATA_W-1:0] rd_int;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] lane_oe;
  logic [DATA_W-1:0] addr_on_ad;
  logic              in_addr;
  logic              in_wdata;

  assign narrow    = !cfg_bus16;
  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  mxb_area_dec #(
    .AREAS (AREAS),
    .AREA_W(AREA_W),
    .WAIT_W(WAIT_W)
  ) u_area (
    .tag_i (req_addr[ADDR_W-1 -: AREA_W]),
    .base_i(cfg_area_base),
    .mask_i(cfg_area_mask),
    .wait_i(cfg_area_wait),
    .wait_o(area_wait)
  );

  mxb_seq #(
    .WAIT_W(WAIT_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start),
    .wait_i (area_wait),
    .phase_o(phase),
    .last_o (last)
  );

  mxb_lane #(
    .LANES(LANES)
  ) u_lane (
    .swap_i   (cfg_little),
    .narrow_i (narrow),
    .wdata_i  (wdata_q),
    .ad_i     (bus_ad_in),
    .be_i     (be_q),
    .wdata_o  (wd_ext),
    .rdata_o  (rd_int),
    .lane_en_o(lane_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      write_q <= 1'b0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
      write_q <= req_write;
    end
  end

  // capture coincides with the edge that releases the read strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= last;
      if (last && !write_q) rsp_rdata <= rd_int;
    end
  end

  assign lane_oe    = narrow ? {{(DATA_W-8){1'b0}}, 8'hFF} : '1;
  assign addr_on_ad = narrow ? {{(DATA_W-8){1'b0}}, addr_q[7:0]} : addr_q[DATA_W-1:0];
  assign in_addr    = (phase == PH_ADDR);
  assign in_wdata   = (phase == PH_DATA) && write_q;

  always_comb begin
    bus_ale    = in_addr;
    bus_rd_n   = !((phase == PH_DATA) && !write_q);
    bus_wr_n   = in_wdata ? ~lane_en : '1;
    bus_ad_out = in_addr ? addr_on_ad : (in_wdata ? wd_ext : '0);
    bus_ad_oe  = (in_addr || in_wdata) ? lane_oe : '0;
    bus_ahi_oe = narrow && (phase != PH_IDLE);
    bus_ahi_out = bus_ahi_oe ? addr_q[ADDR_W-1 -: HI_W] : '0;
  end

  assign port_free_adhi = narrow;
  assign port_free_ahi  = !narrow;
endmodule

// File: rtl/mxb_ctrl_chk.sv
module mxb_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int WAIT_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                bus_ale,
  input logic                bus_rd_n,
  input logic [DATA_W/8-1:0] bus_wr_n,
  input logic [DATA_W-1:0]   bus_ad_oe,
  input logic                bus_ahi_oe
);
  localparam int MAXW = (1 << WAIT_W) - 1;
  localparam int CW   = WAIT_W + 2;

  logic [CW-1:0] since_ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   since_ale <= '0;
    else if (bus_ale)             since_ale <= CW'(1);
    else if (since_ale != '0 && since_ale != '1) since_ale <= since_ale + 1'b1;
  end

  p_start_ale_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_ale);
  p_ale_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);
  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> !req_ready);
  p_no_strobe_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && (&bus_wr_n)));
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !(&bus_wr_n)));
  p_access_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (since_ale >= CW'(2) && since_ale <= CW'(MAXW + 2)));
  p_read_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (bus_ad_oe == '0));
  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_rsp_strobes_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (bus_rd_n && (&bus_wr_n)));
  p_pin_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ahi_oe && (|bus_ad_oe[DATA_W-1:8])));
  p_ready_at_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
endmodule

bind mxb_ctrl mxb_ctrl_chk #(
  .DATA_W(DATA_W),
  .WAIT_W(WAIT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .bus_ale   (bus_ale),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .bus_ad_oe (bus_ad_oe),
  .bus_ahi_oe(bus_ahi_oe)
);

// File: tb/tb_mxb_ctrl.sv
module tb_mxb_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bus16 = 1'b1;
  logic        cfg_little = 1'b0;
  logic [15:0] cfg_area_base = '0;
  logic [15:0] cfg_area_mask = '0;
  logic [11:0] cfg_area_wait = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        bus_ale;
  logic        bus_rd_n;
  logic [1:0]  bus_wr_n;
  logic [15:0] bus_ad_out;
  logic [15:0] bus_ad_oe;
  logic [15:0] bus_ad_in = '0;
  logic [7:0]  bus_ahi_out;
  logic        bus_ahi_oe;
  logic        port_free_adhi;
  logic        port_free_ahi;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mxb_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16), .cfg_little(cfg_little),
    .cfg_area_base(cfg_area_base), .cfg_area_mask(cfg_area_mask),
    .cfg_area_wait(cfg_area_wait), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_ahi_out(bus_ahi_out), .bus_ahi_oe(bus_ahi_oe),
    .port_free_adhi(port_free_adhi), .port_free_ahi(port_free_ahi)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] swp(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  function automatic int exp_wait(input logic [3:0] tag);
    for (int i = 0; i < 4; i++) begin
      if (((tag ^ cfg_area_base[i*4 +: 4]) & cfg_area_mask[i*4 +: 4]) == 4'h0)
        return int'(cfg_area_wait[i*3 +: 3]);
    end
    return 7;
  endfunction

  // entered and left at a negedge with the design idle
  task automatic access(input logic wr, input logic [15:0] a, input logic [15:0] wd,
                        input logic [1:0] be, input logic [15:0] din);
    int w;
    logic [15:0] e_oe, e_adr, e_wd, e_rd;
    logic [1:0]  e_wr;
    logic [7:0]  e_hi;
    logic        e_hoe;
    w     = exp_wait(a[15:12]);
    e_oe  = cfg_bus16 ? 16'hFFFF : 16'h00FF;
    e_adr = cfg_bus16 ? a : {8'h00, a[7:0]};
    e_hoe = !cfg_bus16;
    e_hi  = cfg_bus16 ? 8'h00 : a[15:8];
    if (cfg_bus16) begin
      e_wd = cfg_little ? swp(wd) : wd;
      e_wr = ~(cfg_little ? {be[0], be[1]} : be);
      e_rd = cfg_little ? swp(din) : din;
    end else begin
      e_wd = {8'h00, wd[7:0]};
      e_wr = 2'b10;
      e_rd = {8'h00, din[7:0]};
    end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    bus_ad_in = din;
    @(negedge clk);
    req_valid = 1'b0;
    // address phase
    chk("R1 R8 address phase", {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, bus_ad_out,
        bus_ahi_oe, bus_ahi_out, req_ready},
        {1'b1, 1'b1, 2'b11, e_oe, e_adr, e_hoe, e_hi, 1'b0});
    // strobe phase, 1+W cycles
    for (int k = 0; k <= w; k++) begin
      @(negedge clk);
      if (wr)
        chk("R2 R3 R5 R6 R7 R8 write strobe", {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe,
            bus_ad_out & bus_ad_oe, bus_ahi_oe, bus_ahi_out},
            {1'b0, 1'b1, e_wr, e_oe, e_wd, e_hoe, e_hi});
      else
        chk("R2 R3 R4 R8 read strobe", {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe,
            bus_ahi_oe, bus_ahi_out},
            {1'b0, 1'b0, 2'b11, 16'h0000, e_hoe, e_hi});
    end
    @(negedge clk);
    chk("R2 R10 response cycle", {rsp_valid, req_ready, bus_ale, bus_rd_n, bus_wr_n,
        bus_ad_oe, bus_ahi_oe}, {1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 16'h0000, 1'b0});
    if (!wr) chk("R4 R6 R7 read data", {48'h0, rsp_rdata}, {48'h0, e_rd});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [3:0] tags [4];
    tags[0] = 4'h1; tags[1] = 4'h5; tags[2] = 4'h9; tags[3] = 4'hD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset state", {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, bus_ahi_oe,
        rsp_valid, req_ready}, {1'b0, 1'b1, 2'b11, 16'h0000, 1'b0, 1'b0, 1'b1});

    // overlapping table: entry2 (8..B) outranks entry3 (8..F) on tag 9
    cfg_area_base = {4'h8, 4'h8, 4'h4, 4'h0};
    cfg_area_mask = {4'h8, 4'hC, 4'hC, 4'hC};
    seed = 1;
    for (int m = 0; m < 2; m++) begin
      for (int le = 0; le < 2; le++) begin
        cfg_bus16  = (m == 1);
        cfg_little = (le == 1);
        @(negedge clk);
        chk("R8 port release", {port_free_adhi, port_free_ahi},
            {!cfg_bus16, cfg_bus16});
        for (int w = 0; w < 8; w++) begin
          for (int i = 0; i < 4; i++) cfg_area_wait[i*3 +: 3] = 3'((w + i) % 8);
          for (int t = 0; t < 4; t++) begin
            for (int op = 0; op < 2; op++) begin
              seed++;
              access(op == 0, {tags[t], 12'(seed * 37)}, 16'(seed * 16'h1357 + 16'h0A5),
                     2'(seed), 16'(seed * 16'h2B9D) ^ 16'hC3A5);
            end
          end
        end
      end
    end

    // R3: unmatched tag takes seven waits, matched tag its own count
    cfg_bus16 = 1'b1; cfg_little = 1'b0;
    cfg_area_base = {4'h3, 4'h2, 4'h1, 4'h0};
    cfg_area_mask = 16'hFFFF;
    cfg_area_wait = {3'd0, 3'd3, 3'd0, 3'd0};
    access(1'b0, 16'h5ABC, 16'h0000, 2'b00, 16'h9E41);
    access(1'b1, 16'h5123, 16'hBEEF, 2'b11, 16'h0000);
    access(1'b0, 16'h2F0F, 16'h0000, 2'b00, 16'h7788);
    access(1'b1, 16'h2001, 16'h1234, 2'b00, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule